// File: doc/BRIEF.md
# Depth Tile Range Compressor

This block takes in one square tile of depth samples (8x8 by default, 32 bits each) on a valid/ready input stream, in raster order. As each sample arrives, it is written into a tile buffer and folded into a running lowest and highest value. Once the last sample of the tile is in, the block chooses one of three encodings from the spread between those two values:

- **Constant**: every sample is the same, so a single value is sent.
- **Packed**: every sample is sent as a small offset above the lowest value.
- **Raw**: every sample is sent unchanged.

The block then streams a header word and the payload on a valid/ready output stream.

While a tile is being emitted, the lowest and highest depth of that tile are also held on a side output. A coarse depth-rejection stage can use them to accept or discard whole tiles without reading the samples. Input is stalled for as long as a tile is being sent out. The next tile then starts from fresh bounds.

Top module: `depth_tile_compressor`

## Requirements
- R1: After a synchronous active-high reset, `inReady` is 1, `outValid` is 0, `bndValid` is 0, and `tileMin` and `tileMax` are both 0.
- R2: The block accepts exactly 64 samples per tile on cycles where `inValid` and `inReady` are both high. `inReady` is 0 from the cycle after the 64th sample is accepted until the cycle after the tile's final output word is accepted.
- R3: While a tile is being emitted, `bndValid` is 1 and `tileMin`/`tileMax` hold that tile's unsigned lowest and highest sample, stable until the final word is accepted. The bounds are recomputed from each tile's first sample, so values from earlier tiles have no effect.
- R4: The first output word of each tile is a header. Bits [1:0] hold the encoding code: 00 for constant, 01 for packed, 10 for raw. All other header bits are 0.
- R5: If the highest and lowest samples are equal, the tile is emitted as two words: a header with code 00, then the common value. `outLast` is set on the second word.
- R6: If the spread (highest minus lowest) is between 1 and 15, the tile is emitted as ten words: a header with code 01, the lowest value, then 8 payload words. In payload word w (0 to 7), bits [4k+3:4k] carry sample (8w+k) minus the lowest value.
- R7: If the spread is 16 or more, the tile is emitted as 65 words: a header with code 10, then the 64 samples unchanged and in arrival order.
- R8: The spread is an unsigned difference. A spread of exactly 15 selects packed and a spread of exactly 16 selects raw, including for samples near the top of the 32-bit range.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outLast` hold their values into the next cycle.
- R10: Cycles with `inValid` at 0 add no sample and change no stored sample, whatever is on `inData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block can accept a sample |
| inData | input | 32 | Depth sample, raster order |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | 32 | Header, lowest value or payload word |
| outLast | output | 1 | Marks the final word of a tile |
| bndValid | output | 1 | Tile bounds on `tileMin`/`tileMax` are valid |
| tileMin | output | 32 | Lowest depth in the current tile |
| tileMax | output | 32 | Highest depth in the current tile |

## Verification
The assertions assume that downstream eventually raises `outReady`, and that reset is held for at least one clock edge before any traffic. They make no assumption about the pattern of `inValid`: gaps between samples and arbitrary data during idle cycles are allowed.

The bench keeps `outReady` at 0 throughout the input phase. During emission it releases `outReady` in a repeating pattern, so every tile finishes. It only raises `inValid` after reset has been released. Idle input cycles carry junk data on purpose, so that the property of ignoring non-handshake cycles is actually exercised.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    CLS_CONST  = 2'b00,
    CLS_PACKED = 2'b01,
    CLS_RAW    = 2'b10
  } tileClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // a sample is accepted this cycle
    logic firstSample;  // the accepted sample opens a new tile
    logic emitting;     // tile is being streamed out
  } dpCtrl_t;

endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
#(
  parameter int NUM_SAMPLES = 64,
  parameter int PACK_WORDS  = 8,
  parameter int CNTW        = 6,
  parameter int IDXW        = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            outReady,
  input  tileClass_e      tileClass,
  output logic            inReady,
  output logic            outValid,
  output logic            outLast,
  output logic [CNTW-1:0] sampleIdx,
  output logic [IDXW-1:0] wordIdx,
  output dpCtrl_t         strobes
);

  typedef enum logic {ST_COLLECT, ST_EMIT} state_e;

  localparam logic [CNTW-1:0] LAST_SAMPLE = CNTW'(NUM_SAMPLES - 1);
  localparam logic [IDXW-1:0] LAST_CONST  = IDXW'(1);
  localparam logic [IDXW-1:0] LAST_PACKED = IDXW'(1 + PACK_WORDS);
  localparam logic [IDXW-1:0] LAST_RAW    = IDXW'(NUM_SAMPLES);

  state_e          state;
  logic [CNTW-1:0] sampleCnt;
  logic [IDXW-1:0] wordCnt;
  logic [IDXW-1:0] lastIdx;

  always_comb begin
    case (tileClass)
      CLS_CONST:  lastIdx = LAST_CONST;
      CLS_PACKED: lastIdx = LAST_PACKED;
      default:    lastIdx = LAST_RAW;
    endcase
  end

  assign inReady   = (state == ST_COLLECT);
  assign outValid  = (state == ST_EMIT);
  assign outLast   = outValid && (wordCnt == lastIdx);
  assign sampleIdx = sampleCnt;
  assign wordIdx   = wordCnt;

  always_comb begin
    strobes.capture     = inValid && inReady;
    strobes.firstSample = (sampleCnt == '0);
    strobes.emitting    = outValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_COLLECT;
      sampleCnt <= '0;
      wordCnt   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (strobes.capture) begin
            if (sampleCnt == LAST_SAMPLE) begin
              sampleCnt <= '0;
              wordCnt   <= '0;
              state     <= ST_EMIT;
            end else begin
              sampleCnt <= sampleCnt + 1'b1;
            end
          end
        end
        default: begin
          if (outReady) begin
            if (outLast) begin
              wordCnt <= '0;
              state   <= ST_COLLECT;
            end else begin
              wordCnt <= wordCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int SAMPLE_W      = 32,
  parameter int OFFSET_W      = 4,
  parameter int NUM_SAMPLES   = 64,
  parameter int PACK_PER_WORD = 8,
  parameter int CNTW          = 6,
  parameter int IDXW          = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  dpCtrl_t             strobes,
  input  logic [CNTW-1:0]     sampleIdx,
  input  logic [IDXW-1:0]     wordIdx,
  input  logic [SAMPLE_W-1:0] inData,
  output tileClass_e          tileClass,
  output logic [SAMPLE_W-1:0] outData,
  output logic [SAMPLE_W-1:0] minVal,
  output logic [SAMPLE_W-1:0] maxVal
);

  localparam logic [SAMPLE_W-1:0] PACK_LIMIT = SAMPLE_W'(1) << OFFSET_W;

  logic [SAMPLE_W-1:0] sampleMem [NUM_SAMPLES];
  logic [SAMPLE_W-1:0] minReg, maxReg;
  logic [SAMPLE_W-1:0] rangeVal;
  logic [SAMPLE_W-1:0] headerWord, rawWord, packWord;
  logic [CNTW-1:0]     packBase;

  // tile buffer
  always_ff @(posedge clk) begin
    if (strobes.capture) sampleMem[sampleIdx] <= inData;
  end

  // running bounds, reopened by the first sample of each tile
  always_ff @(posedge clk) begin
    if (rst) begin
      minReg <= '0;
      maxReg <= '0;
    end else if (strobes.capture) begin
      if (strobes.firstSample) begin
        minReg <= inData;
        maxReg <= inData;
      end else begin
        if (inData < minReg) minReg <= inData;
        if (inData > maxReg) maxReg <= inData;
      end
    end
  end

  assign rangeVal = maxReg - minReg;

  always_comb begin
    if (rangeVal == '0)             tileClass = CLS_CONST;
    else if (rangeVal < PACK_LIMIT) tileClass = CLS_PACKED;
    else                            tileClass = CLS_RAW;
  end

  assign headerWord = {{(SAMPLE_W-2){1'b0}}, tileClass};
  assign rawWord    = sampleMem[CNTW'(int'(wordIdx) - 1)];
  assign packBase   = CNTW'((int'(wordIdx) - 2) * PACK_PER_WORD);

  // offsets only need the low bits of the difference
  always_comb begin
    packWord = '0;
    for (int k = 0; k < PACK_PER_WORD; k++) begin
      packWord[k*OFFSET_W +: OFFSET_W] =
        sampleMem[CNTW'(int'(packBase) + k)][OFFSET_W-1:0] - minReg[OFFSET_W-1:0];
    end
  end

  always_comb begin
    if (wordIdx == '0)              outData = headerWord;
    else if (tileClass == CLS_RAW)  outData = rawWord;
    else if (wordIdx == IDXW'(1))   outData = minReg;
    else                            outData = packWord;
  end

  assign minVal = minReg;
  assign maxVal = maxReg;

endmodule

// File: rtl/depth_tile_compressor.sv
module depth_tile_compressor
  import dtc_pkg::*;
#(
  parameter int TILE_DIM = 8,
  parameter int SAMPLE_W = 32,
  parameter int OFFSET_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                outValid,
  input  logic                outReady,
  output logic [SAMPLE_W-1:0] outData,
  output logic                outLast,
  output logic                bndValid,
  output logic [SAMPLE_W-1:0] tileMin,
  output logic [SAMPLE_W-1:0] tileMax
);

  localparam int NUM_SAMPLES   = TILE_DIM * TILE_DIM;
  localparam int PACK_PER_WORD = SAMPLE_W / OFFSET_W;
  localparam int PACK_WORDS    = NUM_SAMPLES / PACK_PER_WORD;
  localparam int CNTW          = $clog2(NUM_SAMPLES);
  localparam int IDXW          = $clog2(NUM_SAMPLES + 1);

  dpCtrl_t         strobes;
  tileClass_e      tileClass;
  logic [CNTW-1:0] sampleIdx;
  logic [IDXW-1:0] wordIdx;

  dtc_ctrl #(
    .NUM_SAMPLES(NUM_SAMPLES), .PACK_WORDS(PACK_WORDS),
    .CNTW(CNTW), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .tileClass(tileClass), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .sampleIdx(sampleIdx), .wordIdx(wordIdx),
    .strobes(strobes)
  );

  dtc_datapath #(
    .SAMPLE_W(SAMPLE_W), .OFFSET_W(OFFSET_W), .NUM_SAMPLES(NUM_SAMPLES),
    .PACK_PER_WORD(PACK_PER_WORD), .CNTW(CNTW), .IDXW(IDXW)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .sampleIdx(sampleIdx),
    .wordIdx(wordIdx), .inData(inData), .tileClass(tileClass),
    .outData(outData), .minVal(tileMin), .maxVal(tileMax)
  );

  assign bndValid = strobes.emitting;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int SAMPLE_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                inReady,
  input logic                outValid,
  input logic                outReady,
  input logic [SAMPLE_W-1:0] outData,
  input logic                outLast,
  input logic                bndValid,
  input logic [SAMPLE_W-1:0] tileMin,
  input logic [SAMPLE_W-1:0] tileMax
);

  logic firstWord;

  always_ff @(posedge clk) begin
    if (rst) firstWord <= 1'b1;
    else if (outValid && outReady) firstWord <= outLast;
  end

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R3
  bounds_order_chk: assert property (@(posedge clk) disable iff (rst)
    bndValid |-> tileMin <= tileMax);

  // R3
  bounds_stable_chk: assert property (@(posedge clk) disable iff (rst)
    bndValid && !(outReady && outLast) |=> $stable(tileMin) && $stable(tileMax));

  // R4
  header_code_chk: assert property (@(posedge clk) disable iff (rst)
    firstWord && outValid |-> outData[1:0] != 2'b11 && outData[SAMPLE_W-1:2] == '0);

  // R5
  const_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    firstWord && outValid && outData[1:0] == 2'b00 |-> tileMin == tileMax);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

endmodule

bind depth_tile_compressor dtc_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outLast(outLast),
  .bndValid(bndValid), .tileMin(tileMin), .tileMax(tileMax)
);

// File: tb/depth_tile_compressor_test.sv
module depth_tile_compressor_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, inReady, outValid, outReady, outLast, bndValid;
  logic [31:0] inData, outData, tileMin, tileMax;

  int checks = 0;
  int failures = 0;

  logic [31:0] tile [64];
  logic [31:0] expW [65];
  logic [31:0] got  [65];
  int          expCount;
  logic [31:0] expMin, expMax;

  always #5 clk = ~clk;

  depth_tile_compressor uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .bndValid(bndValid),
    .tileMin(tileMin), .tileMax(tileMax)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic buildExpected();
    logic [31:0] rng;
    expMin = tile[0];
    expMax = tile[0];
    for (int i = 1; i < 64; i++) begin
      if (tile[i] < expMin) expMin = tile[i];
      if (tile[i] > expMax) expMax = tile[i];
    end
    rng = expMax - expMin;
    if (rng == 0) begin
      expW[0] = 32'd0; expW[1] = expMin; expCount = 2;
    end else if (rng < 16) begin
      expW[0] = 32'd1; expW[1] = expMin; expCount = 10;
      for (int w = 0; w < 8; w++) begin
        expW[2+w] = 32'd0;
        for (int k = 0; k < 8; k++) begin
          logic [31:0] off;
          off = tile[w*8+k] - expMin;
          expW[2+w][k*4 +: 4] = off[3:0];
        end
      end
    end else begin
      expW[0] = 32'd2; expCount = 65;
      for (int i = 0; i < 64; i++) expW[1+i] = tile[i];
    end
  endtask

  // drives a tile and streams it back out, checking every word
  task automatic runTile(string req, bit gaps, bit stalls);
    int n = 0;
    bit done = 0;
    bit held = 0;
    logic [31:0] heldData = 0;
    logic heldLast = 0;
    buildExpected();
    for (int i = 0; i < 64; i++) begin
      if (gaps) begin
        for (int g = 0; g < (i % 3); g++) begin
          @(negedge clk);
          inValid = 1'b0;
          inData  = 32'hDEAD_0000 + i;
        end
      end
      forever begin
        @(negedge clk);
        inValid = 1'b1;
        inData  = tile[i];
        if (inReady) break;
      end
    end
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = 32'hBAD0_BAD0;
      if (held) begin
        check("R9", "held outValid", {31'd0, outValid}, 32'd1);
        check("R9", "held outData", outData, heldData);
        check("R9", "held outLast", {31'd0, outLast}, {31'd0, heldLast});
        held = 0;
      end
      if (cyc == 0) begin
        check("R2", "inReady during emit", {31'd0, inReady}, 32'd0);
        check("R3", "bndValid", {31'd0, bndValid}, 32'd1);
        check("R3", "tileMin", tileMin, expMin);
        check("R3", "tileMax", tileMax, expMax);
      end
      outReady = stalls ? ((cyc % 3) != 2) : 1'b1;
      if (outValid && outReady) begin
        if (n < 65) got[n] = outData;
        check(req, "outLast position", {31'd0, outLast}, {31'd0, (n == expCount - 1)});
        n++;
        if (outLast) done = 1;
      end else if (outValid) begin
        held = 1; heldData = outData; heldLast = outLast;
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    check("R2", "inReady after tile", {31'd0, inReady}, 32'd1);
    check("R3", "bndValid after tile", {31'd0, bndValid}, 32'd0);
    check(req, "word count", n, expCount);
    for (int i = 0; i < expCount && i < n; i++)
      check((i == 0) ? "R4" : req, $sformatf("word %0d", i), got[i], expW[i]);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "inReady", {31'd0, inReady}, 32'd1);
    check("R1", "outValid", {31'd0, outValid}, 32'd0);
    check("R1", "bndValid", {31'd0, bndValid}, 32'd0);
    check("R1", "tileMin", tileMin, 32'd0);
    check("R1", "tileMax", tileMax, 32'd0);
  endtask

  task automatic testConstant(logic [31:0] v, bit stalls);
    for (int i = 0; i < 64; i++) tile[i] = v;
    runTile("R5", 1'b0, stalls);
  endtask

  task automatic testPackedEdge();
    // spread exactly 15
    for (int i = 0; i < 64; i++) tile[i] = 32'd1000 + ((i * 7) % 16);
    runTile("R8", 1'b0, 1'b1);
  endtask

  task automatic testPackedTwoLevels();
    for (int i = 0; i < 64; i++) tile[i] = 32'h0ABC_0000 + ((i % 5) == 0 ? 1 : 0);
    runTile("R6", 1'b0, 1'b0);
  endtask

  task automatic testRawEdge();
    // spread exactly 16
    for (int i = 0; i < 64; i++) tile[i] = 32'd500 + ((i == 5) ? 16 : (i % 4));
    runTile("R8", 1'b0, 1'b0);
  endtask

  task automatic testHighPacked();
    // follows a tile with a lower minimum: bounds must restart (R3)
    for (int i = 0; i < 64; i++) tile[i] = 32'hFFFF_FFF0 + (i % 16);
    runTile("R3", 1'b0, 1'b1);
  endtask

  task automatic testRawGaps();
    for (int i = 0; i < 64; i++) tile[i] = (i * 32'h0101_0101) ^ 32'h5A00_00A5;
    runTile("R10", 1'b1, 1'b1);
  endtask

  task automatic testRawWide();
    for (int i = 0; i < 64; i++) tile[i] = 32'h8000_0000 - i * 32'd977;
    runTile("R7", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inData = '0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testConstant(32'h1234_5678, 1'b0);
    testPackedEdge();
    testRawEdge();
    testHighPacked();
    testPackedTwoLevels();
    testRawGaps();
    testConstant(32'd0, 1'b1);
    testRawWide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule